// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces all-bank auto-refresh for a DDR3-class memory controller. An interval timer counted in controller clock cycles adds one unit of refresh debt each time it expires. While any debt is owed the block raises a refresh request toward the command arbiter. When the arbiter grants the request, one unit of debt is paid off. A busy window then opens and keeps every other bank command off the bus for the full refresh-cycle time. All eight banks are covered by a single refresh, so no per-bank state is held.

A synchronous `hot_i` flag, set while the case temperature is above the threshold, selects the short interval. The short interval is half the normal one, which doubles the refresh rate. If the flag rises part-way through a long interval, the time left is cut at once so that no interval is longer than the current temperature allows. If the flag falls, the interval already running finishes at the short length. Debt is capped at eight owed refreshes. An urgent flag tells the arbiter when that cap has been reached.

Defaults assume an 800 MHz controller clock: 6240 cycles for the normal interval, 3120 cycles when hot, and 128 cycles of busy time after each refresh.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, and right after it is released, req_o, urgent_o and busy_o are all low.
- R2: With hot_i low and each request granted on the cycle it appears, successive rising edges of req_o are exactly NORM_IVL cycles apart.
- R3: With hot_i high and each request granted on the cycle it appears, successive rising edges of req_o are exactly HOT_IVL cycles apart.
- R4: If hot_i goes high while more than HOT_IVL-1 cycles of a normal interval remain, the next debt unit arrives HOT_IVL cycles after the first clock edge that samples hot_i high.
- R5: If hot_i goes low, the interval already running completes at HOT_IVL cycles, and the intervals after it are NORM_IVL cycles long.
- R6: req_o is high whenever debt is non-zero and busy_o is low, and it stays high until a grant is accepted.
- R7: A grant is accepted when gnt_i and req_o are both high at a clock edge. An accepted grant removes one debt unit, and busy_o is then high for exactly TRFC_CYC consecutive cycles, starting the cycle after the grant.
- R8: While busy_o is high, req_o is low and gnt_i has no effect: debt does not change and the busy window is not extended.
- R9: urgent_o is high exactly when the debt equals DEBT_MAX (8 owed refreshes by default), and low whenever the debt is below DEBT_MAX.
- R10: When an interval expires with the debt already at DEBT_MAX, the debt stays at DEBT_MAX.
- R11: When a grant is accepted in the same cycle that an interval expires, the debt is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hot_i | input | 1 | Case temperature above threshold, synchronous to clk_i |
| gnt_i | input | 1 | Arbiter accepts the pending refresh |
| req_o | output | 1 | Refresh owed and the bus is free for it |
| urgent_o | output | 1 | Debt has reached its cap |
| busy_o | output | 1 | Refresh-cycle window is open; other commands are blocked |

## Verification
The assertions assume that `hot_i` and `gnt_i` are synchronous to the clock. They also assume that a grant only counts when it coincides with a visible request; a grant at any other time, including during the busy window, is expected to do nothing. The stimulus changes `hot_i` and `gnt_i` only on the falling clock edge. Grants are driven either in direct response to `req_o` or as a deliberate probe inside the busy window. Temperature changes are placed at known offsets from a request, so that the expected spacing of the next requests can be computed in advance.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

  localparam int unsigned NORM_IVL_DEF = 6240;  // 7.8 us at 800 MHz
  localparam int unsigned HOT_IVL_DEF  = 3120;  // 3.9 us at 800 MHz
  localparam int unsigned TRFC_DEF     = 128;   // 160 ns at 800 MHz
  localparam int unsigned DEBT_MAX_DEF = 8;

  typedef enum logic [1:0] {
    DEBT_HOLD = 2'd0,
    DEBT_INC  = 2'd1,
    DEBT_DEC  = 2'd2
  } debt_op_e;

endpackage

// File: rtl/refsch_ivl_timer.sv
module refsch_ivl_timer
  import refsch_pkg::*;
#(
  parameter int unsigned NORM_IVL = NORM_IVL_DEF,
  parameter int unsigned HOT_IVL  = HOT_IVL_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  output logic tick_o
);

  localparam int unsigned CW = $clog2(NORM_IVL);
  localparam logic [CW-1:0] NORM_LD = CW'(NORM_IVL - 1);
  localparam logic [CW-1:0] HOT_LD  = CW'(HOT_IVL - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (tick_o) begin
      cnt_d = hot_i ? HOT_LD : NORM_LD;
    end else if (hot_i && (cnt_q > HOT_LD)) begin
      // cut a long interval short as soon as the part runs hot
      cnt_d = HOT_LD;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= NORM_LD;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/refsch_debt_ctr.sv
module refsch_debt_ctr
  import refsch_pkg::*;
#(
  parameter int unsigned DEBT_MAX = DEBT_MAX_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic pending_o,
  output logic full_o
);

  localparam int unsigned DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] DEBT_TOP = DW'(DEBT_MAX);

  logic [DW-1:0] debt_q;
  debt_op_e      op;

  always_comb begin
    unique case ({tick_i, take_i})
      2'b10:   op = DEBT_INC;
      2'b01:   op = DEBT_DEC;
      default: op = DEBT_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else begin
      unique case (op)
        DEBT_INC: if (debt_q != DEBT_TOP) debt_q <= debt_q + 1'b1;
        DEBT_DEC: if (debt_q != '0)       debt_q <= debt_q - 1'b1;
        default:  debt_q <= debt_q;
      endcase
    end
  end

  assign pending_o = (debt_q != '0);
  assign full_o    = (debt_q == DEBT_TOP);

endmodule

// File: rtl/refsch_busy_win.sv
module refsch_busy_win
  import refsch_pkg::*;
#(
  parameter int unsigned TRFC_CYC = TRFC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);

  localparam int unsigned BW = $clog2(TRFC_CYC + 1);
  localparam logic [BW-1:0] WIN_LD = BW'(TRFC_CYC);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (start_i)        left_q <= WIN_LD;
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy_o = (left_q != '0);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsch_pkg::*;
#(
  parameter int unsigned NORM_IVL = NORM_IVL_DEF,
  parameter int unsigned HOT_IVL  = HOT_IVL_DEF,
  parameter int unsigned TRFC_CYC = TRFC_DEF,
  parameter int unsigned DEBT_MAX = DEBT_MAX_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hot_i,
  input  logic gnt_i,
  output logic req_o,
  output logic urgent_o,
  output logic busy_o
);

  logic tick;
  logic pending;
  logic take;

  refsch_ivl_timer #(
    .NORM_IVL(NORM_IVL),
    .HOT_IVL (HOT_IVL)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hot_i (hot_i),
    .tick_o(tick)
  );

  refsch_debt_ctr #(
    .DEBT_MAX(DEBT_MAX)
  ) i_debt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .take_i   (take),
    .pending_o(pending),
    .full_o   (urgent_o)
  );

  refsch_busy_win #(
    .TRFC_CYC(TRFC_CYC)
  ) i_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(take),
    .busy_o (busy_o)
  );

  // no request is offered inside the refresh-cycle window
  assign req_o = pending & ~busy_o;
  assign take  = gnt_i & req_o;

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int unsigned TRFC_CYC = 128
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_i,
  input logic req_o,
  input logic urgent_o,
  input logic busy_o
);

  localparam int unsigned RW = $clog2(TRFC_CYC + 2);

  logic [RW-1:0] busy_run;

  // cycles busy_o has been high so far in the current window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              busy_run <= '0;
    else if (!busy_o)                         busy_run <= '0;
    else if (busy_run != RW'(TRFC_CYC + 1))   busy_run <= busy_run + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_quiet_R1: assert (!req_o && !urgent_o && !busy_o);
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> req_o);

  assert_grant_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && gnt_i) |=> busy_o);

  assert_busy_max_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < RW'(TRFC_CYC)));

  assert_busy_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run == RW'(TRFC_CYC)));

  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_o);

  assert_urgent_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    urgent_o |-> (req_o || busy_o));

  assert_urgent_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (urgent_o && !(req_o && gnt_i)) |=> urgent_o);

endmodule

bind refresh_sched refresh_sched_chk #(
  .TRFC_CYC(TRFC_CYC)
) i_refresh_sched_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gnt_i   (gnt_i),
  .req_o   (req_o),
  .urgent_o(urgent_o),
  .busy_o  (busy_o)
);

// File: tb/test_refresh_sched.sv
`timescale 1ns/1ps
module test_refresh_sched;

  localparam int unsigned NORM_IVL = 40;
  localparam int unsigned HOT_IVL  = 20;
  localparam int unsigned TRFC_CYC = 6;
  localparam int unsigned DEBT_MAX = 8;

  typedef struct {
    int    gap;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hot_i = 1'b0;
  logic gnt_i = 1'b0;
  logic req_o, urgent_o, busy_o;

  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   auto_gnt = 1'b0;
  exp_t sb_q[$];

  refresh_sched #(
    .NORM_IVL(NORM_IVL),
    .HOT_IVL (HOT_IVL),
    .TRFC_CYC(TRFC_CYC),
    .DEBT_MAX(DEBT_MAX)
  ) i_refresh_sched (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .hot_i   (hot_i),
    .gnt_i   (gnt_i),
    .req_o   (req_o),
    .urgent_o(urgent_o),
    .busy_o  (busy_o)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!req_o) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // auto-grant responder
  initial forever begin
    @(negedge clk);
    if (auto_gnt) gnt_i = req_o;
  end

  // scoreboard monitor: spacing between request rising edges
  initial begin
    bit   req_prev = 1'b0;
    int   last_rise = 0;
    exp_t it;
    forever begin
      @(negedge clk);
      if (rst_ni && req_o && !req_prev) begin
        if (sb_q.size() != 0) begin
          it = sb_q.pop_front();
          check((cyc - last_rise) == it.gap, it.tag, cyc - last_rise, it.gap);
        end
        last_rise = cyc;
      end
      req_prev = req_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int cnt;
    // R1: reset state
    wait_n(3);
    check(!req_o, "R1 req_o in reset", int'(req_o), 0);
    check(!urgent_o, "R1 urgent_o in reset", int'(urgent_o), 0);
    check(!busy_o, "R1 busy_o in reset", int'(busy_o), 0);
    rst_ni = 1'b1;
    wait_n(2);
    check(!req_o && !urgent_o && !busy_o, "R1 outputs after release",
          int'({req_o, urgent_o, busy_o}), 0);

    // R2: cool spacing
    auto_gnt = 1'b1;
    wait_rise();
    @(negedge clk);
    repeat (3) sb_q.push_back('{NORM_IVL, "R2 cool spacing"});
    wait_drain();

    // R4 then R3: hot raised one cycle after a request
    wait_rise();
    @(negedge clk);
    hot_i = 1'b1;
    sb_q.push_back('{HOT_IVL + 2, "R4 hot cuts interval"});
    repeat (2) sb_q.push_back('{HOT_IVL, "R3 hot spacing"});
    wait_drain();

    // R5: cooling lets the running short interval finish
    wait_rise();
    @(negedge clk);
    hot_i = 1'b0;
    sb_q.push_back('{HOT_IVL, "R5 running interval stays short"});
    sb_q.push_back('{NORM_IVL, "R5 next interval normal"});
    wait_drain();

    // debt accumulation
    wait_n(3);
    auto_gnt = 1'b0;
    gnt_i = 1'b0;
    hot_i = 1'b1;
    wait_rise();                    // first unit owed (T1)
    wait_n(6 * HOT_IVL);            // seven units owed
    check(req_o, "R6 req held without grant", int'(req_o), 1);
    check(!urgent_o, "R9 urgent low below cap", int'(urgent_o), 0);
    wait_n(HOT_IVL);                // eight owed
    check(urgent_o, "R9 urgent at cap", int'(urgent_o), 1);
    wait_n(HOT_IVL);                // one more interval, saturated
    check(urgent_o, "R10 debt saturates", int'(urgent_o), 1);

    gnt_i = 1'b1;
    wait_n(1);
    gnt_i = 1'b0;
    check(!urgent_o, "R9 urgent drops after grant", int'(urgent_o), 0);
    cnt = 0;
    while (busy_o) begin
      cnt++;
      check(!req_o, "R8 req blocked in busy", int'(req_o), 0);
      if (cnt == 2) gnt_i = 1'b1;    // probe: ignored while busy
      if (cnt == 3) gnt_i = 1'b0;
      @(negedge clk);
    end
    check(cnt == TRFC_CYC, "R7 busy length", cnt, TRFC_CYC);
    check(req_o, "R6 request resumes after busy", int'(req_o), 1);

    // R11: grant lands on the next interval expiry (T1+180)
    wait_n(12);
    gnt_i = 1'b1;
    wait_n(1);
    gnt_i = 1'b0;
    check(!urgent_o, "R11 debt unchanged on coincident grant", int'(urgent_o), 0);
    check(busy_o, "R7 busy after coincident grant", int'(busy_o), 1);
    wait_n(HOT_IVL);
    check(urgent_o, "R11 cap reached again", int'(urgent_o), 1);

    finish_run();
  end

endmodule